// File: doc/BRIEF.md
# Byte and Halfword Reorder Unit

This combinational unit executes the byte-shuffle and sign-extension group of a 64-bit integer datapath. It takes a full 32-bit instruction word and the value of the `rt` source register. It decodes the instruction and returns three things: the destination register index, the 64-bit result, and a pair of flags. One flag says the result should be written. The other says the instruction belongs to this group but is not a legal encoding.

The supported operations are:
- swapping the two bytes inside each halfword of the low word, with sign extension of the word result;
- the same byte swap applied across all four halfwords of the doubleword;
- reversing the order of the four halfwords;
- sign extension of the low byte;
- sign extension of the low halfword.

A mode input says whether 64-bit operations are enabled. Without it, the two doubleword forms are treated as reserved.

Register file access and exception delivery belong to the surrounding pipeline. This block only reports the flags.

Top module: `hsx_reorder`

## Requirements
- R1: With major opcode 011111 (bits [31:26]), rs field [25:21] zero, function [5:0] = 100000 and sub-op [10:6] = 00010, the result swaps the bytes inside each halfword of `rt_val[31:0]` and fills bits [63:32] with bit 31 of that swapped word. `rd_we` is 1.
- R2: With function 100100, sub-op 00010 and `wide_mode` = 1, each of the four halfwords of `rt_val` has its two bytes exchanged. `rd_we` is 1.
- R3: With function 100100, sub-op 00101 and `wide_mode` = 1, the halfwords are reversed: result[15:0] = rt[63:48], [31:16] = rt[47:32], [47:32] = rt[31:16], [63:48] = rt[15:0]. `rd_we` is 1.
- R4: With function 100000 and sub-op 10000, the result is `rt_val[7:0]` sign-extended to 64 bits. `rd_we` is 1.
- R5: With function 100000 and sub-op 11000, the result is `rt_val[15:0]` sign-extended to 64 bits. `rd_we` is 1.
- R6: The doubleword forms (function 100100) with `wide_mode` = 0 raise `rsvd_insn` and leave `rd_we` at 0. The word forms work in either mode.
- R7: An instruction with opcode 011111 and one of the two function codes raises `rsvd_insn` with `rd_we` = 0 in two cases: the rs field is nonzero, or the sub-op is not listed for that function.
- R8: Any other opcode, or any other function code under opcode 011111, leaves both `rd_we` and `rsvd_insn` at 0.
- R9: `rd_idx` always equals instruction bits [15:11].
- R10: `rd_we` and `rsvd_insn` are never both 1, and `rd_data` is zero whenever `rd_we` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word |
| rt_val | input | 64 | Value of the rt source register |
| wide_mode | input | 1 | 1 enables the doubleword forms |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | 64 | Result value, zero when not writing |
| rd_we | output | 1 | Result should be written to rd |
| rsvd_insn | output | 1 | Reserved encoding within this group |

## Verification
The checker watches the following on every input change:
- the flag pair stays exclusive, and the data stays zero when no write is made;
- the destination index follows the instruction;
- foreign encodings never raise either flag;
- doubleword forms never write while 64-bit mode is off;
- sign-extended results (word swap, byte and halfword extension) have all upper bits equal to the sign bit.

The exact byte and halfword placement of each permutation can only be shown by the bench's scenarios. The same holds for which specific rs values and sub-op codes count as reserved. The bench compares full 64-bit results against values it computes independently, using patterns with both sign polarities.

// File: rtl/hsx_pkg.sv
package hsx_pkg;
  localparam logic [5:0] OPC_SPECIAL3 = 6'b011111;
  localparam logic [5:0] FN_WORD      = 6'b100000;
  localparam logic [5:0] FN_DWORD     = 6'b100100;
  localparam logic [4:0] SUB_BSWAP    = 5'b00010;
  localparam logic [4:0] SUB_HREV     = 5'b00101;
  localparam logic [4:0] SUB_SEXT8    = 5'b10000;
  localparam logic [4:0] SUB_SEXT16   = 5'b11000;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_WSWAP,
    OP_DSWAP,
    OP_HREV,
    OP_SEXT8,
    OP_SEXT16
  } hsx_op_e;
endpackage

// File: rtl/hsx_decode.sv
module hsx_decode
  import hsx_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [4:0] rs_fld,
  input  logic [4:0] sub_op,
  input  logic [5:0] funct,
  input  logic       wide_mode,
  output hsx_op_e    op,
  output logic       claimed
);
  logic is_word, is_dword;

  always_comb begin
    is_word  = (opcode == OPC_SPECIAL3) && (funct == FN_WORD);
    is_dword = (opcode == OPC_SPECIAL3) && (funct == FN_DWORD);
    claimed  = is_word || is_dword;
    op       = OP_NONE;
    if (rs_fld == 5'd0) begin
      if (is_word) begin
        case (sub_op)
          SUB_BSWAP:  op = OP_WSWAP;
          SUB_SEXT8:  op = OP_SEXT8;
          SUB_SEXT16: op = OP_SEXT16;
          default:    op = OP_NONE;
        endcase
      end else if (is_dword && wide_mode) begin
        case (sub_op)
          SUB_BSWAP: op = OP_DSWAP;
          SUB_HREV:  op = OP_HREV;
          default:   op = OP_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/hsx_permute.sv
module hsx_permute #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] wswap,
  output logic [DATA_W-1:0] dswap,
  output logic [DATA_W-1:0] hrev,
  output logic [DATA_W-1:0] sext8,
  output logic [DATA_W-1:0] sext16
);
  localparam int HALF_W   = 16;
  localparam int NUM_HALF = DATA_W / HALF_W;
  localparam int WORD_W   = 32;

  logic [DATA_W-1:0] swapped;

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    assign swapped[h*HALF_W +: 8]     = src[h*HALF_W + 8 +: 8];
    assign swapped[h*HALF_W + 8 +: 8] = src[h*HALF_W +: 8];
    assign hrev[h*HALF_W +: HALF_W]   = src[(NUM_HALF-1-h)*HALF_W +: HALF_W];
  end

  assign dswap  = swapped;
  assign wswap  = {{(DATA_W-WORD_W){swapped[WORD_W-1]}}, swapped[WORD_W-1:0]};
  assign sext8  = {{(DATA_W-8){src[7]}}, src[7:0]};
  assign sext16 = {{(DATA_W-HALF_W){src[HALF_W-1]}}, src[HALF_W-1:0]};
endmodule

// File: rtl/hsx_reorder.sv
module hsx_reorder
  import hsx_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] rt_val,
  input  logic              wide_mode,
  output logic [4:0]        rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_we,
  output logic              rsvd_insn
);
  hsx_op_e           op;
  logic              claimed;
  logic [DATA_W-1:0] r_wswap, r_dswap, r_hrev, r_sext8, r_sext16;

  hsx_decode u_dec (
    .opcode    (instr[31:26]),
    .rs_fld    (instr[25:21]),
    .sub_op    (instr[10:6]),
    .funct     (instr[5:0]),
    .wide_mode (wide_mode),
    .op        (op),
    .claimed   (claimed)
  );

  hsx_permute #(.DATA_W(DATA_W)) u_perm (
    .src    (rt_val),
    .wswap  (r_wswap),
    .dswap  (r_dswap),
    .hrev   (r_hrev),
    .sext8  (r_sext8),
    .sext16 (r_sext16)
  );

  logic unused_rt_fld;
  assign unused_rt_fld = ^instr[20:16];

  always_comb begin
    rd_idx    = instr[15:11];
    rd_we     = (op != OP_NONE);
    rsvd_insn = claimed && (op == OP_NONE);
    case (op)
      OP_WSWAP:  rd_data = r_wswap;
      OP_DSWAP:  rd_data = r_dswap;
      OP_HREV:   rd_data = r_hrev;
      OP_SEXT8:  rd_data = r_sext8;
      OP_SEXT16: rd_data = r_sext16;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/hsx_reorder_chk.sv
module hsx_reorder_chk #(
  parameter int DATA_W = 64
) (
  input logic [31:0]       instr,
  input logic [DATA_W-1:0] rt_val,
  input logic              wide_mode,
  input logic [4:0]        rd_idx,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_we,
  input logic              rsvd_insn
);
  logic spec3, fn_w, fn_d;
  logic sub_bs, sub_s8, sub_s16, rs_zero;
  logic unused_rt;

  always_comb begin
    spec3     = instr[31:26] == 6'b011111;
    fn_w      = instr[5:0] == 6'b100000;
    fn_d      = instr[5:0] == 6'b100100;
    sub_bs    = instr[10:6] == 5'b00010;
    sub_s8    = instr[10:6] == 5'b10000;
    sub_s16   = instr[10:6] == 5'b11000;
    rs_zero   = instr[25:21] == 5'd0;
    unused_rt = ^rt_val;

    assert_flag_excl_R10: assert (!(rd_we && rsvd_insn));
    assert_zero_idle_R10: assert (rd_we || rd_data == '0);
    assert_dest_idx_R9:   assert (rd_idx == instr[15:11]);
    if (!(spec3 && (fn_w || fn_d)))
      assert_foreign_quiet_R8: assert (!rd_we && !rsvd_insn);
    if (spec3 && fn_d && !wide_mode)
      assert_narrow_block_R6: assert (!rd_we && rsvd_insn);
    if (spec3 && (fn_w || fn_d) && !rs_zero)
      assert_rs_nonzero_R7: assert (rsvd_insn && !rd_we);
    if (rd_we && spec3 && fn_w && sub_bs && rs_zero)
      assert_wswap_sext_R1: assert (rd_data[DATA_W-1:31] == '0 || &rd_data[DATA_W-1:31]);
    if (rd_we && spec3 && fn_w && sub_s8 && rs_zero)
      assert_sext8_upper_R4: assert (rd_data[DATA_W-1:7] == '0 || &rd_data[DATA_W-1:7]);
    if (rd_we && spec3 && fn_w && sub_s16 && rs_zero)
      assert_sext16_upper_R5: assert (rd_data[DATA_W-1:15] == '0 || &rd_data[DATA_W-1:15]);
  end
endmodule

bind hsx_reorder hsx_reorder_chk #(.DATA_W(DATA_W)) u_chk (
  .instr     (instr),
  .rt_val    (rt_val),
  .wide_mode (wide_mode),
  .rd_idx    (rd_idx),
  .rd_data   (rd_data),
  .rd_we     (rd_we),
  .rsvd_insn (rsvd_insn)
);

// File: tb/hsx_reorder_tb.sv
module hsx_reorder_tb;
  logic        clk;
  logic        rst_n;
  logic [31:0] instr;
  logic [63:0] rt_val;
  logic        wide_mode;
  logic [4:0]  rd_idx;
  logic [63:0] rd_data;
  logic        rd_we;
  logic        rsvd_insn;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  hsx_reorder u_dut (
    .instr     (instr),
    .rt_val    (rt_val),
    .wide_mode (wide_mode),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .rd_we     (rd_we),
    .rsvd_insn (rsvd_insn)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] enc(input logic [5:0] opc, input logic [4:0] rs,
                                      input logic [4:0] rd, input logic [4:0] sa,
                                      input logic [5:0] fn);
    return {opc, rs, 5'd3, rd, sa, fn};
  endfunction

  task automatic check(input string req, input logic [63:0] exp_d,
                       input logic exp_we, input logic exp_rsvd, input logic [4:0] exp_rd);
    n_checks++;
    if (rd_data !== exp_d || rd_we !== exp_we || rsvd_insn !== exp_rsvd || rd_idx !== exp_rd) begin
      n_errors++;
      $display("FAIL %s: got data=%h we=%b rsvd=%b rd=%0d, expected data=%h we=%b rsvd=%b rd=%0d",
               req, rd_data, rd_we, rsvd_insn, rd_idx, exp_d, exp_we, exp_rsvd, exp_rd);
    end
  endtask

  task automatic apply(input logic [31:0] i, input logic [63:0] v, input logic w);
    @(negedge clk);
    instr = i; rt_val = v; wide_mode = w;
    #2;
  endtask

  function automatic logic [63:0] exp_wswap(input logic [63:0] v);
    logic [31:0] w;
    w = {v[23:16], v[31:24], v[7:0], v[15:8]};
    return {{32{w[31]}}, w};
  endfunction

  function automatic logic [63:0] exp_dswap(input logic [63:0] v);
    logic [63:0] r;
    for (int k = 0; k < 4; k++) begin
      r[16*k +: 8]     = v[16*k + 8 +: 8];
      r[16*k + 8 +: 8] = v[16*k +: 8];
    end
    return r;
  endfunction

  task automatic t_reset_state();
    apply(32'h0, 64'h0, 1'b0);
    check("R8 idle", 64'h0, 1'b0, 1'b0, 5'd0);
  endtask

  task automatic t_wswap();
    apply(enc(6'h1f, 5'd0, 5'd7, 5'b00010, 6'b100000), 64'hFFFF_0000_1234_5678, 1'b1);
    check("R1 wswap pos", exp_wswap(64'hFFFF_0000_1234_5678), 1'b1, 1'b0, 5'd7);
    apply(enc(6'h1f, 5'd0, 5'd9, 5'b00010, 6'b100000), 64'h0000_0000_1280_ABCD, 1'b0);
    check("R1 wswap neg narrow", exp_wswap(64'h0000_0000_1280_ABCD), 1'b1, 1'b0, 5'd9);
  endtask

  task automatic t_dswap();
    apply(enc(6'h1f, 5'd0, 5'd4, 5'b00010, 6'b100100), 64'h0123_4567_89AB_CDEF, 1'b1);
    check("R2 dswap", exp_dswap(64'h0123_4567_89AB_CDEF), 1'b1, 1'b0, 5'd4);
    apply(enc(6'h1f, 5'd0, 5'd4, 5'b00010, 6'b100100), 64'hFF00_00FF_A55A_1122, 1'b1);
    check("R2 dswap b", 64'h00FF_FF00_5AA5_2211, 1'b1, 1'b0, 5'd4);
  endtask

  task automatic t_hrev();
    apply(enc(6'h1f, 5'd0, 5'd31, 5'b00101, 6'b100100), 64'h1111_2222_3333_4444, 1'b1);
    check("R3 hrev", 64'h4444_3333_2222_1111, 1'b1, 1'b0, 5'd31);
  endtask

  task automatic t_sext();
    apply(enc(6'h1f, 5'd0, 5'd2, 5'b10000, 6'b100000), 64'h1234_5678_9ABC_DE80, 1'b1);
    check("R4 sext8 neg", 64'hFFFF_FFFF_FFFF_FF80, 1'b1, 1'b0, 5'd2);
    apply(enc(6'h1f, 5'd0, 5'd2, 5'b10000, 6'b100000), 64'hFFFF_FFFF_FFFF_FF7F, 1'b0);
    check("R4 sext8 pos", 64'h0000_0000_0000_007F, 1'b1, 1'b0, 5'd2);
    apply(enc(6'h1f, 5'd0, 5'd5, 5'b11000, 6'b100000), 64'h0000_0000_0001_8001, 1'b1);
    check("R5 sext16 neg", 64'hFFFF_FFFF_FFFF_8001, 1'b1, 1'b0, 5'd5);
    apply(enc(6'h1f, 5'd0, 5'd5, 5'b11000, 6'b100000), 64'hFFFF_FFFF_FFFF_7FFE, 1'b1);
    check("R5 sext16 pos", 64'h0000_0000_0000_7FFE, 1'b1, 1'b0, 5'd5);
  endtask

  task automatic t_narrow();
    apply(enc(6'h1f, 5'd0, 5'd6, 5'b00010, 6'b100100), 64'h0123_4567_89AB_CDEF, 1'b0);
    check("R6 dswap narrow", 64'h0, 1'b0, 1'b1, 5'd6);
    apply(enc(6'h1f, 5'd0, 5'd6, 5'b00101, 6'b100100), 64'h0123_4567_89AB_CDEF, 1'b0);
    check("R6 hrev narrow", 64'h0, 1'b0, 1'b1, 5'd6);
  endtask

  task automatic t_reserved();
    apply(enc(6'h1f, 5'd1, 5'd8, 5'b00010, 6'b100000), 64'h1234_5678_9ABC_DEF0, 1'b1);
    check("R7 rs nonzero", 64'h0, 1'b0, 1'b1, 5'd8);
    apply(enc(6'h1f, 5'd16, 5'd8, 5'b00101, 6'b100100), 64'h1234_5678_9ABC_DEF0, 1'b1);
    check("R7 rs nonzero dword", 64'h0, 1'b0, 1'b1, 5'd8);
    apply(enc(6'h1f, 5'd0, 5'd8, 5'b00101, 6'b100000), 64'h1234_5678_9ABC_DEF0, 1'b1);
    check("R7 bad subop word", 64'h0, 1'b0, 1'b1, 5'd8);
    apply(enc(6'h1f, 5'd0, 5'd8, 5'b10000, 6'b100100), 64'h1234_5678_9ABC_DEF0, 1'b1);
    check("R7 bad subop dword", 64'h0, 1'b0, 1'b1, 5'd8);
  endtask

  task automatic t_foreign();
    apply(enc(6'h1e, 5'd0, 5'd10, 5'b00010, 6'b100000), 64'h1234_5678_9ABC_DEF0, 1'b1);
    check("R8 other opcode", 64'h0, 1'b0, 1'b0, 5'd10);
    apply(enc(6'h1f, 5'd0, 5'd11, 5'b00010, 6'b000000), 64'h1234_5678_9ABC_DEF0, 1'b1);
    check("R8 other funct", 64'h0, 1'b0, 1'b0, 5'd11);
  endtask

  task automatic t_dest_sweep();
    for (int r = 0; r < 32; r += 5) begin
      apply(enc(6'h1f, 5'd0, r[4:0], 5'b11000, 6'b100000), 64'h0000_0000_0000_1234, 1'b0);
      check("R9 R10 dest", 64'h1234, 1'b1, 1'b0, r[4:0]);
    end
  endtask

  initial begin
    rst_n = 1'b0; instr = '0; rt_val = '0; wide_mode = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_wswap();
    t_dswap();
    t_hrev();
    t_sext();
    t_narrow();
    t_reserved();
    t_foreign();
    t_dest_sweep();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule